// File: doc/BRIEF.md
# System Opcode and CSR Execution Unit

This unit executes the system class of instructions for a 32-bit integer core. Each cycle the core may present one instruction word with its first source register value. The unit decodes the funct3 field and the 12-bit field in bits [31:20]. It then does one of three things. It performs an atomic read-modify-write on an internal bank of control and status registers. It identifies one of the environment or return instructions. Or it flags the word as illegal. The memory-ordering opcode is accepted as a no-operation.

Results come out two clock cycles after the instruction is presented. They are a register write-back (enable, destination index, old CSR value), a redirect (valid plus target PC), a halt pulse for environment calls, an event code and an illegal-instruction flag. A new instruction may be presented every cycle. An operation that reads a CSR sees the value written by the operation issued one cycle earlier. The CSR bank is kept in a block-RAM-style array, and a per-entry "written" bit makes every CSR read as zero after reset.

Top module: `sys_csr_unit`

## Requirements
- R1: An accepted word has opcode bits [6:0] = 7'b1110011. Its funct3 (bits [14:12]) selects the operation: 001 swap, 010 set, 011 clear, 101 swap-immediate, 110 set-immediate, 111 clear-immediate. The CSR address is bits [31:20], unsigned. The destination index is bits [11:7].
- R2: Swap and swap-immediate always store the new value. They assert `wb_en` with the old value only when the destination index is not 0.
- R3: Set stores old OR source and clear stores old AND NOT source. Both forms assert `wb_en` with the old value, whatever the destination index.
- R4: For the four set/clear forms, a source field (bits [19:15]) of zero suppresses the CSR store only. The old value is still returned on `wb_data` with `wb_en` high.
- R5: The immediate forms use the 5-bit source field itself, zero-extended, in place of `src_value`.
- R6: With funct3 000, the 12-bit field selects an event on `sys_event`: 0x000 gives code 1, 0x001 gives 2, 0x002 gives 3, 0x102 gives 4 and 0x302 gives 5. Code 0 means no event.
- R7: Code 1 (environment call) raises `halt` for one cycle, together with the event.
- R8: Code 5 (machine return) raises `jump_en` with `jump_pc` equal to the current content of CSR 0x341.
- R9: Opcode 7'b0001111 (fence) and any other opcode that is not the system opcode produce no output and change no CSR.
- R10: funct3 100, or funct3 000 with any 12-bit field outside R6, raises `illegal`. Nothing is written back and no CSR changes.
- R11: Reset (synchronous, active high) clears every output, and every CSR then reads as zero.
- R12: Results appear exactly two cycles after `in_valid`. An operation issued in the cycle after a CSR store sees the stored value.
- R13: Only the low `CSR_IDX_W` (default 10) bits of the CSR address select an entry, so addresses that differ only above that bit alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word |
| src_value | input | XLEN | Value of the register named by bits [19:15] |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Write-back destination index |
| wb_data | output | XLEN | Old CSR value to write back |
| jump_en | output | 1 | Redirect valid |
| jump_pc | output | XLEN | Redirect target |
| halt | output | 1 | Environment call seen |
| sys_event | output | 3 | Event code (R6) |
| illegal | output | 1 | Unrecognised system encoding |

## Verification
The bench targets the suppression rules. A swap with destination 0 must not write back, which catches a design that ignores the index. A set with source field 0 but a nonzero `src_value` must leave the CSR unchanged, which catches a design that checks the register value instead of the field. A clear must drop exactly the masked bits. A machine return issued right after a store to 0x341 must redirect to the new value, not the stale RAM output, which exposes a missing bypass. Illegal words, fence and foreign opcodes are followed by reads of the targeted CSR so that silent writes show up. An alias write through 0x741 checks the index truncation.

// File: rtl/sys_csr_pkg.sv
package sys_csr_pkg;

  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [11:0] F12_ECALL  = 12'h000;
  localparam logic [11:0] F12_EBREAK = 12'h001;
  localparam logic [11:0] F12_URET   = 12'h002;
  localparam logic [11:0] F12_SRET   = 12'h102;
  localparam logic [11:0] F12_MRET   = 12'h302;

  typedef enum logic [1:0] {
    CSR_SWAP  = 2'd0,
    CSR_SET   = 2'd1,
    CSR_CLEAR = 2'd2
  } csr_fn_e;

  typedef enum logic [2:0] {
    EV_NONE   = 3'd0,
    EV_ECALL  = 3'd1,
    EV_EBREAK = 3'd2,
    EV_URET   = 3'd3,
    EV_SRET   = 3'd4,
    EV_MRET   = 3'd5
  } sys_ev_e;

  typedef struct packed {
    logic        is_csr;
    logic        use_imm;
    csr_fn_e     fn;
    sys_ev_e     ev;
    logic        bad;
    logic [4:0]  src_f;
    logic [4:0]  dst_f;
    logic [11:0] csr_addr;
  } sys_dec_t;

endpackage

// File: rtl/sys_decode.sv
module sys_decode
  import sys_csr_pkg::*;
(
  input  logic [31:0] word,
  output sys_dec_t    dec
);

  logic [2:0]  f3;
  logic [11:0] f12;
  logic        is_sys;

  assign f3     = word[14:12];
  assign f12    = word[31:20];
  assign is_sys = (word[6:0] == OPC_SYSTEM);

  always_comb begin
    dec          = '0;
    dec.src_f    = word[19:15];
    dec.dst_f    = word[11:7];
    dec.csr_addr = f12;
    dec.fn       = CSR_SWAP;
    dec.ev       = EV_NONE;
    if (is_sys) begin
      unique case (f3)
        3'b001: begin dec.is_csr = 1'b1; dec.fn = CSR_SWAP;  end
        3'b010: begin dec.is_csr = 1'b1; dec.fn = CSR_SET;   end
        3'b011: begin dec.is_csr = 1'b1; dec.fn = CSR_CLEAR; end
        3'b101: begin dec.is_csr = 1'b1; dec.fn = CSR_SWAP;  dec.use_imm = 1'b1; end
        3'b110: begin dec.is_csr = 1'b1; dec.fn = CSR_SET;   dec.use_imm = 1'b1; end
        3'b111: begin dec.is_csr = 1'b1; dec.fn = CSR_CLEAR; dec.use_imm = 1'b1; end
        3'b000: begin
          unique case (f12)
            F12_ECALL:  dec.ev = EV_ECALL;
            F12_EBREAK: dec.ev = EV_EBREAK;
            F12_URET:   dec.ev = EV_URET;
            F12_SRET:   dec.ev = EV_SRET;
            F12_MRET:   dec.ev = EV_MRET;
            default:    dec.bad = 1'b1;
          endcase
        end
        default: dec.bad = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/csr_store.sv
module csr_store #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data
);

  logic [XLEN-1:0] mem [DEPTH];
  logic [DEPTH-1:0] written_q;
  logic [XLEN-1:0] mem_q;
  logic            vld_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    mem_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      vld_q     <= 1'b0;
    end else begin
      vld_q <= written_q[rd_idx];
      if (wr_en) written_q[wr_idx] <= 1'b1;
    end
  end

  assign rd_data = vld_q ? mem_q : '0;

endmodule

// File: rtl/csr_alu.sv
module csr_alu
  import sys_csr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_fn_e         fn,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] new_val
);

  always_comb begin
    unique case (fn)
      CSR_SET:   new_val = old_val | operand;
      CSR_CLEAR: new_val = old_val & ~operand;
      default:   new_val = operand;
    endcase
  end

endmodule

// File: rtl/sys_csr_unit.sv
module sys_csr_unit
  import sys_csr_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CSR_IDX_W = 10,
  parameter logic [11:0] MEPC_ADDR = 12'h341
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_word,
  input  logic [XLEN-1:0] src_value,
  output logic            wb_en,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            jump_en,
  output logic [XLEN-1:0] jump_pc,
  output logic            halt,
  output logic [2:0]      sys_event,
  output logic            illegal
);

  localparam int ZEXT_W = XLEN - 5;

  sys_dec_t             dec;
  logic [CSR_IDX_W-1:0] rd_idx_in;

  sys_dec_t             s1_dec;
  logic                 s1_valid;
  logic [XLEN-1:0]      s1_src;
  logic [CSR_IDX_W-1:0] s1_idx;
  logic                 s1_fwd;
  logic [XLEN-1:0]      s1_fwd_data;

  logic [XLEN-1:0] ram_rdata;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] operand;
  logic [XLEN-1:0] new_val;
  logic            csr_wr;
  logic            wb_ok;

  sys_decode u_dec (
    .word (in_word),
    .dec  (dec)
  );

  // Machine return reads the saved PC instead of the field's address.
  assign rd_idx_in = (dec.ev == EV_MRET) ? MEPC_ADDR[CSR_IDX_W-1:0]
                                         : dec.csr_addr[CSR_IDX_W-1:0];

  generate
    if (CSR_IDX_W < 12) begin : g_hi_bits
      logic unused_hi;
      assign unused_hi = ^{dec.csr_addr[11:CSR_IDX_W], MEPC_ADDR[11:CSR_IDX_W]};
    end
  endgenerate

  // Stage 1: capture decode and launch the synchronous CSR read.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid    <= 1'b0;
      s1_dec      <= '0;
      s1_src      <= '0;
      s1_idx      <= '0;
      s1_fwd      <= 1'b0;
      s1_fwd_data <= '0;
    end else begin
      s1_valid    <= in_valid;
      s1_dec      <= dec;
      s1_src      <= src_value;
      s1_idx      <= rd_idx_in;
      // A store landing at this edge is not seen by the RAM read: bypass it.
      s1_fwd      <= csr_wr && (s1_idx == rd_idx_in);
      s1_fwd_data <= new_val;
    end
  end

  csr_store #(
    .XLEN  (XLEN),
    .IDX_W (CSR_IDX_W)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .rd_idx  (rd_idx_in),
    .rd_data (ram_rdata),
    .wr_en   (csr_wr),
    .wr_idx  (s1_idx),
    .wr_data (new_val)
  );

  // Stage 2: modify and write back.
  assign old_val = s1_fwd ? s1_fwd_data : ram_rdata;
  assign operand = s1_dec.use_imm ? {{ZEXT_W{1'b0}}, s1_dec.src_f} : s1_src;

  csr_alu #(
    .XLEN (XLEN)
  ) u_alu (
    .fn      (s1_dec.fn),
    .old_val (old_val),
    .operand (operand),
    .new_val (new_val)
  );

  assign csr_wr = s1_valid && s1_dec.is_csr &&
                  ((s1_dec.fn == CSR_SWAP) || (s1_dec.src_f != 5'd0));
  assign wb_ok  = s1_valid && s1_dec.is_csr &&
                  ((s1_dec.fn != CSR_SWAP) || (s1_dec.dst_f != 5'd0));

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      jump_en   <= 1'b0;
      jump_pc   <= '0;
      halt      <= 1'b0;
      sys_event <= EV_NONE;
      illegal   <= 1'b0;
    end else begin
      wb_en     <= wb_ok;
      wb_idx    <= s1_dec.dst_f;
      wb_data   <= old_val;
      jump_en   <= s1_valid && (s1_dec.ev == EV_MRET);
      jump_pc   <= old_val;
      halt      <= s1_valid && (s1_dec.ev == EV_ECALL);
      sys_event <= s1_valid ? s1_dec.ev : EV_NONE;
      illegal   <= s1_valid && s1_dec.bad;
    end
  end

  // R10: an illegal word leaves no other trace on the outputs.
  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!wb_en && !jump_en && !halt));

  // R7: halt only accompanies the environment-call code.
  a_r7_halt_code: assert property (@(posedge clk) disable iff (rst)
    halt |-> (sys_event == EV_ECALL));

  // R8: a redirect only accompanies the machine-return code.
  a_r8_jump_code: assert property (@(posedge clk) disable iff (rst)
    jump_en |-> (sys_event == EV_MRET));

  // R12: every write-back traces to a word two cycles back.
  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> $past(in_valid, 2));

  // R2: a swap aimed at index 0 produces no write-back.
  a_r2_swap_x0: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_dec.is_csr && s1_dec.fn == CSR_SWAP && s1_dec.dst_f == 5'd0)
      |=> !wb_en);

  // R9: words outside the system opcode never modify CSR state.
  a_r9_foreign_no_store: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[6:0] != OPC_SYSTEM) |=> !csr_wr);

endmodule

// File: tb/sys_csr_unit_tb.sv
`timescale 1ns/1ps
module sys_csr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic [31:0] src_value = '0;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        jump_en;
  logic [31:0] jump_pc;
  logic        halt;
  logic [2:0]  sys_event;
  logic        illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sys_csr_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .src_value(src_value), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .jump_en(jump_en), .jump_pc(jump_pc), .halt(halt),
    .sys_event(sys_event), .illegal(illegal)
  );

  function automatic logic [31:0] enc(input logic [11:0] f12, input logic [4:0] s,
                                      input logic [2:0] f3, input logic [4:0] d);
    return {f12, s, f3, d, 7'b1110011};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Present one word, then sample the result two edges later.
  task automatic issue(input logic [31:0] w, input logic [31:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; src_value = s;
    @(negedge clk);
    in_valid = 1'b0; in_word = '0; src_value = '0;
    @(negedge clk);
  endtask

  // Read a CSR with a set of source field 0 into index 5.
  task automatic read_csr(input logic [11:0] a, output logic [31:0] v);
    issue(enc(a, 5'd0, 3'b010, 5'd5), 32'hFFFF_FFFF);
    v = wb_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R11 wb_en after reset", {31'b0, wb_en}, 32'd0);
    chk("R11 flags after reset", {26'b0, jump_en, halt, illegal, sys_event}, 32'd0);
    read_csr(12'h300, v);
    chk("R11 csr zero", v, 32'd0);
    chk("R4 read-only wb_en", {31'b0, wb_en}, 32'd1);
    read_csr(12'h341, v);
    chk("R11 mepc zero", v, 32'd0);
  endtask

  task automatic t_swap;
    logic [31:0] v;
    issue(enc(12'h300, 5'd7, 3'b001, 5'd1), 32'hDEAD_BEEF);
    chk("R1 swap wb_en", {31'b0, wb_en}, 32'd1);
    chk("R1 swap idx", {27'b0, wb_idx}, 32'd1);
    chk("R1 swap old", wb_data, 32'd0);
    read_csr(12'h300, v);
    chk("R1 swap stored", v, 32'hDEAD_BEEF);
    issue(enc(12'h300, 5'd7, 3'b001, 5'd0), 32'h1234_5678);
    chk("R2 swap x0 no wb", {31'b0, wb_en}, 32'd0);
    read_csr(12'h300, v);
    chk("R2 swap x0 still stores", v, 32'h1234_5678);
  endtask

  task automatic t_set_clear;
    logic [31:0] v;
    issue(enc(12'h300, 5'd3, 3'b010, 5'd0), 32'hF000_000F);
    chk("R3 set wb_en with x0", {31'b0, wb_en}, 32'd1);
    chk("R3 set old", wb_data, 32'h1234_5678);
    read_csr(12'h300, v);
    chk("R3 set result", v, 32'hF234_567F);
    issue(enc(12'h300, 5'd3, 3'b011, 5'd4), 32'h0000_0F0F);
    chk("R3 clear old", wb_data, 32'hF234_567F);
    read_csr(12'h300, v);
    chk("R3 clear result", v, 32'hF234_5070);
    issue(enc(12'h300, 5'd0, 3'b011, 5'd6), 32'hFFFF_FFFF);
    chk("R4 clear field0 wb", wb_data, 32'hF234_5070);
    read_csr(12'h300, v);
    chk("R4 clear field0 no store", v, 32'hF234_5070);
  endtask

  task automatic t_imm;
    logic [31:0] v;
    issue(enc(12'h010, 5'h1F, 3'b101, 5'd2), 32'hAAAA_AAAA);
    chk("R5 swapi old", wb_data, 32'd0);
    read_csr(12'h010, v);
    chk("R5 swapi zext", v, 32'h0000_001F);
    issue(enc(12'h010, 5'h05, 3'b111, 5'd2), 32'hFFFF_FFFF);
    read_csr(12'h010, v);
    chk("R5 cleari", v, 32'h0000_001A);
    issue(enc(12'h010, 5'h00, 3'b110, 5'd2), 32'hFFFF_FFFF);
    chk("R4 seti field0 wb", wb_data, 32'h0000_001A);
    issue(enc(12'h010, 5'h10, 3'b110, 5'd2), 32'hFFFF_FFFF);
    read_csr(12'h010, v);
    chk("R5 seti", v, 32'h0000_001A);
    issue(enc(12'h010, 5'h04, 3'b110, 5'd2), 32'h0);
    read_csr(12'h010, v);
    chk("R5 seti new bit", v, 32'h0000_001E);
  endtask

  task automatic t_events;
    issue(enc(12'h000, 5'd0, 3'b000, 5'd0), 32'h0);
    chk("R6 ecall code", {29'b0, sys_event}, 32'd1);
    chk("R7 ecall halt", {31'b0, halt}, 32'd1);
    issue(enc(12'h001, 5'd0, 3'b000, 5'd0), 32'h0);
    chk("R6 ebreak code", {29'b0, sys_event}, 32'd2);
    chk("R7 ebreak no halt", {31'b0, halt}, 32'd0);
    issue(enc(12'h002, 5'd0, 3'b000, 5'd0), 32'h0);
    chk("R6 uret code", {29'b0, sys_event}, 32'd3);
    issue(enc(12'h102, 5'd0, 3'b000, 5'd0), 32'h0);
    chk("R6 sret code", {29'b0, sys_event}, 32'd4);
    chk("R8 sret no jump", {31'b0, jump_en}, 32'd0);
  endtask

  // Store to the return CSR, then return in the very next cycle.
  task automatic t_mret_bypass;
    @(negedge clk);
    in_valid = 1'b1; in_word = enc(12'h341, 5'd9, 3'b001, 5'd0); src_value = 32'h8000_1234;
    @(negedge clk);
    in_word = enc(12'h302, 5'd0, 3'b000, 5'd0); src_value = '0;
    @(negedge clk);
    in_valid = 1'b0; in_word = '0;
    chk("R12 first op no jump", {31'b0, jump_en}, 32'd0);
    @(negedge clk);
    chk("R8 mret jump_en", {31'b0, jump_en}, 32'd1);
    chk("R8 R12 mret target bypass", jump_pc, 32'h8000_1234);
    chk("R6 mret code", {29'b0, sys_event}, 32'd5);
    chk("R8 mret no wb", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    in_valid = 1'b1; in_word = enc(12'h305, 5'd1, 3'b001, 5'd0); src_value = 32'h0BAD_F00D;
    @(negedge clk);
    in_word = enc(12'h305, 5'd1, 3'b010, 5'd8); src_value = 32'h0000_0002;
    @(negedge clk);
    in_word = enc(12'h305, 5'd0, 3'b010, 5'd9); src_value = '0;
    @(negedge clk);
    in_valid = 1'b0; in_word = '0;
    chk("R12 b2b read sees store", wb_data, 32'h0BAD_F00D);
    chk("R12 b2b idx", {27'b0, wb_idx}, 32'd8);
    @(negedge clk);
    chk("R12 b2b chained set", wb_data, 32'h0BAD_F00F);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    issue({12'h305, 5'd1, 3'b000, 5'd3, 7'b0001111}, 32'hFFFF_FFFF);
    chk("R9 fence quiet", {27'b0, wb_en, jump_en, halt, illegal, |sys_event}, 32'd0);
    issue({12'h305, 5'd1, 3'b001, 5'd3, 7'b0110011}, 32'hFFFF_FFFF);
    chk("R9 foreign quiet", {27'b0, wb_en, jump_en, halt, illegal, |sys_event}, 32'd0);
    read_csr(12'h305, v);
    chk("R9 csr untouched", v, 32'h0BAD_F00F);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    issue(enc(12'h305, 5'd1, 3'b100, 5'd3), 32'h0);
    chk("R10 funct3 100 illegal", {31'b0, illegal}, 32'd1);
    chk("R10 funct3 100 no wb", {31'b0, wb_en}, 32'd0);
    issue(enc(12'h105, 5'd0, 3'b000, 5'd0), 32'h0);
    chk("R10 funct12 illegal", {31'b0, illegal}, 32'd1);
    chk("R10 funct12 no event", {29'b0, sys_event}, 32'd0);
    read_csr(12'h305, v);
    chk("R10 csr untouched", v, 32'h0BAD_F00F);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    issue(enc(12'h741, 5'd2, 3'b001, 5'd0), 32'h0000_4444);
    read_csr(12'h341, v);
    chk("R13 alias 0x741 to 0x341", v, 32'h0000_4444);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_swap();
    t_set_clear();
    t_imm();
    t_events();
    t_mret_bypass();
    t_back_to_back();
    t_ignored();
    t_illegal();
    t_alias();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule